// File: doc/BRIEF.md
# Nibble-Coded Dual-Accumulator Core

This block is a tiny processor that retires one instruction on every clock edge. Each instruction is a 4-bit opcode taken from a separate, read-only program store. The core computes a single program address and receives a window of three consecutive program words. That window holds the opcode and, for the literal instruction, the two nibbles that form an 8-bit constant.

Architectural state is an 8-bit program counter, two 8-bit accumulators (A1 and A2) and an internal data memory of 256 bytes. All results land in A1. A2 is used as the address for loads and stores and as the target of the conditional jump.

A2 can only be written through data address 0. That address stands for A2 itself: a store issued while A2 is zero copies A1 into A2, and a load issued while A2 is zero returns A2. The program counter and both accumulators are driven out for observation.

Top module: `nibcore_top`

## Requirements
- R1: A synchronous active-high reset sets PC, A1 and A2 to 0x00 and clears every data memory byte to 0x00.
- R2: `prog_addr` equals the PC. `prog_win[11:8]` is the program word at PC, `[7:4]` the word at PC+1 and `[3:0]` the word at PC+2, with addresses taken modulo 256. The core never writes program storage.
- R3: Opcode 0000 sets A1 to A1+A2 and opcode 0001 sets A1 to A1−A2, both modulo 256. Every instruction other than a taken jump or a literal advances PC by 1.
- R4: Opcode 0010 rotates A1 left by one bit, so bit 7 enters bit 0. Opcode 0011 shifts A1 left by one bit and fills bit 0 with zero. A2 has no effect on either.
- R5: Opcode 0100 sets A1 to A1 AND A2, 0101 to A1 OR A2, and 0110 to A1 XOR A2. Opcode 0111 inverts A1, independent of A2.
- R6: Opcode 1100 with A2 nonzero writes A1 into data byte A2 and leaves A1 and A2 unchanged.
- R7: Opcode 1101 with A2 nonzero loads data byte A2 into A1.
- R8: Data address 0 is A2. Opcode 1100 with A2 = 0 copies A1 into A2, and opcode 1101 with A2 = 0 loads A2 into A1. A2 changes in no other way.
- R9: Opcode 1110 sets PC to A2 when A1 is nonzero and to PC+1 otherwise.
- R10: Opcode 1111 sets A1 to {word at PC+1, word at PC+2} and advances PC by 3.
- R11: Opcodes 1000, 1001, 1010 and 1011 only advance PC by 1. A1, A2 and data memory are unchanged.
- R12: PC is 8 bits wide and wraps from 0xFF to 0x00, including for a literal that straddles the end of program space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 8 | Program address, equal to PC |
| prog_win | input | 12 | Program words at PC, PC+1 and PC+2, first word in the top nibble |
| dbg_pc | output | 8 | Current program counter |
| dbg_a1 | output | 8 | Accumulator A1 |
| dbg_a2 | output | 8 | Accumulator A2 |

## Verification
The hardest state to reach from the ports is a nonzero A2. No instruction targets A2 directly, so the only route is a store issued while A2 still holds its reset value of zero. Every program in the bench therefore opens with a literal followed by a store, which loads a chosen address into A2. Only after that are indirect memory accesses and taken jumps exercised.

Memory contents are observed only through later loads. The bench writes a byte, runs no-ops over it, and reads it back. It then resets and reads the same address again to show the clear.

The wrap case is driven by running 254 no-ops until PC reaches 0xFE, where a literal takes its second nibble from address 0x00.

// File: rtl/nibcore_pkg.sv
package nibcore_pkg;
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_ROL  = 4'h2;
  localparam logic [3:0] OP_SHL  = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_NOT  = 4'h7;
  localparam logic [3:0] OP_STR  = 4'hC;
  localparam logic [3:0] OP_LD   = 4'hD;
  localparam logic [3:0] OP_CJMP = 4'hE;
  localparam logic [3:0] OP_LIT  = 4'hF;

  // ALU class: top opcode bit clear
  function automatic logic is_alu_op(input logic [3:0] op);
    return (op[3] == 1'b0);
  endfunction

  // unassigned block 10xx
  function automatic logic is_idle_op(input logic [3:0] op);
    return (op[3:2] == 2'b10);
  endfunction
endpackage

// File: rtl/nibcore_alu.sv
module nibcore_alu #(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res
);
  import nibcore_pkg::*;

  function automatic logic [DW-1:0] rot_up(input logic [DW-1:0] v);
    return {v[DW-2:0], v[DW-1]};
  endfunction

  function automatic logic [DW-1:0] shift_up(input logic [DW-1:0] v);
    return {v[DW-2:0], 1'b0};
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_ROL:  res = rot_up(lhs);
      OP_SHL:  res = shift_up(lhs);
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_NOT:  res = ~lhs;
      default: res = lhs;
    endcase
  end
endmodule

// File: rtl/nibcore_pcnext.sv
module nibcore_pcnext #(
  parameter int AW = 8
) (
  input  logic [3:0]    op,
  input  logic          acc_nz,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_nxt,
  output logic          jmp_taken
);
  import nibcore_pkg::*;

  localparam logic [AW-1:0] STEP1 = AW'(1);
  localparam logic [AW-1:0] STEP3 = AW'(3);

  assign jmp_taken = (op == OP_CJMP) && acc_nz;

  always_comb begin
    if (jmp_taken)          pc_nxt = target;
    else if (op == OP_LIT)  pc_nxt = pc + STEP3;
    else                    pc_nxt = pc + STEP1;
  end
endmodule

// File: rtl/nibcore_dmem.sv
module nibcore_dmem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[addr] <= wr_data;
    end
  end

  assign rd_data = cells[addr];

  // R6: a write is visible at the same address one cycle later
  a_r6_store_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cells[$past(addr)] == $past(wr_data));
endmodule

// File: rtl/nibcore_top.sv
module nibcore_top #(
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [2*PW-1:0]   prog_addr,
  input  logic [3*PW-1:0]   prog_win,
  output logic [2*PW-1:0]   dbg_pc,
  output logic [2*PW-1:0]   dbg_a1,
  output logic [2*PW-1:0]   dbg_a2
);
  import nibcore_pkg::*;

  localparam int DW = 2 * PW;
  localparam int AW = DW;

  logic [AW-1:0] pc_q, pc_nxt;
  logic [DW-1:0] a1_q, a2_q, a1_nxt;
  logic [DW-1:0] alu_res, mem_rd, ld_val, lit_val;
  logic [3:0]    op;

  // named internal events
  logic a2_zero, is_str, is_ld, is_lit, alias_wr, mem_we, jmp_taken, idle_op;

  assign op       = prog_win[3*PW-1 -: 4];
  assign lit_val  = prog_win[2*PW-1:0];
  assign a2_zero  = (a2_q == '0);
  assign is_str   = (op == OP_STR);
  assign is_ld    = (op == OP_LD);
  assign is_lit   = (op == OP_LIT);
  assign idle_op  = is_idle_op(op);
  assign alias_wr = is_str && a2_zero;
  assign mem_we   = is_str && !a2_zero;

  nibcore_alu #(.DW(DW)) alu_i (
    .op(op), .lhs(a1_q), .rhs(a2_q), .res(alu_res)
  );

  nibcore_pcnext #(.AW(AW)) pcn_i (
    .op(op), .acc_nz(a1_q != '0), .pc(pc_q), .target(a2_q),
    .pc_nxt(pc_nxt), .jmp_taken(jmp_taken)
  );

  nibcore_dmem #(.DW(DW), .AW(AW)) dmem_i (
    .clk(clk), .rst(rst), .wr_en(mem_we), .addr(a2_q),
    .wr_data(a1_q), .rd_data(mem_rd)
  );

  assign ld_val = a2_zero ? a2_q : mem_rd;

  always_comb begin
    if (is_alu_op(op)) a1_nxt = alu_res;
    else if (is_ld)    a1_nxt = ld_val;
    else if (is_lit)   a1_nxt = lit_val;
    else               a1_nxt = a1_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      a1_q <= '0;
      a2_q <= '0;
    end else begin
      pc_q <= pc_nxt;
      a1_q <= a1_nxt;
      if (alias_wr) a2_q <= a1_q;
    end
  end

  assign prog_addr = pc_q;
  assign dbg_pc    = pc_q;
  assign dbg_a1    = a1_q;
  assign dbg_a2    = a2_q;

  // R1: reset state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dbg_pc == '0) && (dbg_a1 == '0) && (dbg_a2 == '0));

  // R3: sequential flow advances by one
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!jmp_taken && !is_lit) |=> dbg_pc == $past(dbg_pc) + AW'(1));

  // R10: literal advances by three
  a_r10_lit_step: assert property (@(posedge clk) disable iff (rst)
    is_lit |=> dbg_pc == $past(dbg_pc) + AW'(3));

  // R9: taken jump lands on A2
  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    jmp_taken |=> dbg_pc == $past(dbg_a2));

  // R8: A2 moves only through the address-0 alias
  a_r8_a2_hold: assert property (@(posedge clk) disable iff (rst)
    !alias_wr |=> $stable(dbg_a2));

  // R11: idle opcodes keep A1
  a_r11_idle_a1: assert property (@(posedge clk) disable iff (rst)
    idle_op |=> $stable(dbg_a1));

  // R6: store keeps A1
  a_r6_store_keeps_a1: assert property (@(posedge clk) disable iff (rst)
    is_str |=> $stable(dbg_a1));
endmodule

// File: tb/nibcore_top_tb_top.sv
module nibcore_top_tb_top;
  localparam time CYC = 5ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  prog_addr, dbg_pc, dbg_a1, dbg_a2;
  logic [11:0] prog_win;
  logic [3:0]  rom [256];
  logic [7:0]  ap1, ap2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  assign ap1 = prog_addr + 8'd1;
  assign ap2 = prog_addr + 8'd2;
  assign prog_win = {rom[prog_addr], rom[ap1], rom[ap2]};

  nibcore_top dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_win(prog_win),
    .dbg_pc(dbg_pc), .dbg_a1(dbg_a1), .dbg_a2(dbg_a2)
  );

  // expected {pc, a1, a2} after each edge of program one
  localparam logic [23:0] EXP1 [24] = '{
    24'h03_20_00, // R10 lit 20
    24'h04_20_20, // R8 str via alias fills A2
    24'h07_07_20, // R10
    24'h08_27_20, // R3 add
    24'h09_07_20, // R3 sub
    24'h0A_E7_20, // R3 sub wraps
    24'h0B_CF_20, // R4 rol, bit7 into bit0
    24'h0C_9E_20, // R4 shl
    24'h0D_00_20, // R5 and
    24'h0E_20_20, // R5 or
    24'h0F_00_20, // R5 xor
    24'h10_FF_20, // R5 not
    24'h11_FF_20, // R6 str mem[20]
    24'h14_00_20, // R10
    24'h15_FF_20, // R7 ld
    24'h16_FF_20, // R11 op 8
    24'h17_FF_20, // R11 op 9
    24'h18_FF_20, // R11 op A
    24'h19_FF_20, // R11 op B
    24'h1C_00_20, // R10
    24'h1D_00_20, // R9 not taken
    24'h20_81_20, // R10
    24'h20_81_20, // R9 taken to A2
    24'h20_81_20  // R9 taken again
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic load_prog(input logic [131:0] img, input int n);
    for (int i = 0; i < 256; i++) rom[i] = 4'h8;
    for (int i = 0; i < n; i++) rom[i] = img[4*(n-1-i) +: 4];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    load_prog(132'hF20CF07011234567CF00D89ABF00EF81E, 33);
    step();
    step();
    chk("R1 reset pc", dbg_pc, 8'h00);
    chk("R1 reset a1", dbg_a1, 8'h00);
    chk("R1 reset a2", dbg_a2, 8'h00);
    rst = 1'b0;

    for (int s = 0; s < 24; s++) begin
      step();
      chk($sformatf("table step %0d pc", s), dbg_pc, EXP1[s][23:16]);
      chk($sformatf("table step %0d a1", s), dbg_a1, EXP1[s][15:8]);
      chk($sformatf("table step %0d a2", s), dbg_a2, EXP1[s][7:0]);
    end
    chk("R2 prog_addr follows pc", prog_addr, dbg_pc);

    // R6 R7 R11: store, idle op, reload
    rst = 1'b1;
    load_prog(132'hF20CF5AC8F00D, 13);
    do_reset();
    for (int s = 0; s < 7; s++) step();
    chk("R7 reload after idle pc", dbg_pc, 8'h0D);
    chk("R11 memory kept over idle op", dbg_a1, 8'h5A);

    // R1: reset mid-run then memory cleared
    rst = 1'b1;
    step();
    chk("R1 mid-run reset pc", dbg_pc, 8'h00);
    chk("R1 mid-run reset a2", dbg_a2, 8'h00);
    load_prog(132'hF20CD, 5);
    step();
    rst = 1'b0;
    for (int s = 0; s < 3; s++) step();
    chk("R1 memory cleared", dbg_a1, 8'h00);
    chk("R1 memory cleared pc", dbg_pc, 8'h05);

    // R8: load with A2 = 0 returns A2
    rst = 1'b1;
    load_prog(132'hF3CD, 4);
    do_reset();
    step();
    chk("R8 lit before alias load", dbg_a1, 8'h3C);
    step();
    chk("R8 alias load returns A2", dbg_a1, 8'h00);
    chk("R8 alias load a2", dbg_a2, 8'h00);

    // R12: wrap of PC with a straddling literal
    rst = 1'b1;
    load_prog(132'h8, 1);
    rom[8'hFE] = 4'hF;
    rom[8'hFF] = 4'h3;
    do_reset();
    for (int s = 0; s < 254; s++) step();
    chk("R12 pc before wrap", dbg_pc, 8'hFE);
    step();
    chk("R12 pc after wrap", dbg_pc, 8'h01);
    chk("R10 literal across wrap", dbg_a1, 8'h38);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule